// File: doc/BRIEF.md
# Power Button Event and Hold Override Controller

This block turns an active-low, already debounced power button into system events. Pressing the button latches a sticky event flag. Software clears that flag by writing a one to it. A separate enable bit decides whether the latched event is passed on. While the system is awake the event goes out as an SCI, or as an SMI when the SCI enable input is low. While the system is in any sleep state it goes out as a wake request.

While the button stays low, a hold timer counts ticks of a slow time base. When the hold exceeds the configured limit, an override takes place:
- the normal event flag is cleared;
- a separate override flag is set;
- a one-cycle soft-off request goes to the sleep sequencer;
- a lock forces the button to stay armed as the only wake source until the system has slept and resumed.

A synchronous hard reset from the reset-control path clears the enable, the timer and the lock. It leaves both sticky flags untouched, so firmware can still see why the machine restarted.

Top module: `pwrbtn_ctl`

## Requirements
- R1: A high-to-low transition of `btn_ni` sets `btn_sts_o` on the next clock edge, whatever the value of `btn_en_o`.
- R2: A write with `wr_sel_i`=0 is write-one-to-clear. `wr_data_i[0]` clears `btn_sts_o` and `wr_data_i[1]` clears `ovr_sts_o`. A zero in either bit leaves that flag unchanged.
- R3: If a press edge and a write that clears `btn_sts_o` fall in the same cycle, the flag ends up set.
- R4: Counting starts at the press. The override fires on the (HOLD_TICKS+1)-th `tick_i` seen while `btn_ni` stays low. Releasing the button restarts the count from zero.
- R5: On override, the following happen together on one clock edge: `btn_sts_o` clears, `ovr_sts_o` sets, `btn_en_o` and `wake_lock_o` set, and `soft_off_o` goes high for exactly one cycle.
- R6: An override fires at most once per continuous press.
- R7: With `slp_state_i`=0 (awake) and both `btn_sts_o` and `btn_en_o` set, `sci_o` is high when `sci_en_i`=1 and `smi_o` is high when `sci_en_i`=0. The two are never high together.
- R8: With `slp_state_i` in 1..5 (sleep states) and both flags set, `wake_o` is high, and `sci_o` and `smi_o` are low.
- R9: While `wake_lock_o` is high, writes with `wr_sel_i`=1 cannot clear `btn_en_o`. The lock drops on the edge after `slp_state_i` moves from a nonzero value to 0.
- R10: `hard_rst_i` clears `btn_en_o`, `wake_lock_o` and the hold count, and keeps `btn_sts_o` and `ovr_sts_o`.
- R11: After `rst_ni` all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| hard_rst_i | input | 1 | Synchronous reset-control hard reset |
| btn_ni | input | 1 | Debounced power button, low when pressed |
| slp_state_i | input | 3 | Current sleep state, 0 awake, 1..5 sleeping |
| sci_en_i | input | 1 | Route awake events to SCI (1) or SMI (0) |
| tick_i | input | 1 | Slow time base strobe, one cycle wide |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 status (W1C), 1 enable |
| wr_data_i | input | 2 | Write data |
| btn_sts_o | output | 1 | Sticky button event flag |
| ovr_sts_o | output | 1 | Sticky hold override flag |
| btn_en_o | output | 1 | Button event enable |
| wake_lock_o | output | 1 | Button forced as sole wake source |
| sci_o | output | 1 | SCI request |
| smi_o | output | 1 | SMI request |
| wake_o | output | 1 | Wake request |
| soft_off_o | output | 1 | One-cycle forced soft-off request |

## Verification
The checker watches several rules on every cycle:
- SCI, SMI and wake requests are mutually exclusive.
- Every rise of the button flag is preceded by a low button.
- Every fall of the button flag is explained by a clearing write or by an override.
- The soft-off pulse lasts one cycle and lands together with the full set of override side effects.
- The lock always implies the enable.
- A hard reset always leaves the enable and the lock low.

Some behaviours only the bench scenarios can show. These are the exact tick count at which the override fires, the restart of that count on release, and the single firing per press. The bench also shows the set-over-clear race, the lock release on resume, and the survival of the flags across a hard reset.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;
  localparam int unsigned SLP_W = 3;
  localparam int unsigned WD_W  = 2;

  typedef enum logic [SLP_W-1:0] {
    SLP_AWAKE = 3'd0,
    SLP_S1    = 3'd1,
    SLP_S2    = 3'd2,
    SLP_S3    = 3'd3,
    SLP_S4    = 3'd4,
    SLP_OFF   = 3'd5
  } slp_e;

  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_ENABLE = 1'b1;

  localparam int unsigned BIT_BTN = 0;
  localparam int unsigned BIT_OVR = 1;

  function automatic logic is_sleeping(logic [SLP_W-1:0] s);
    return (s >= SLP_S1) && (s <= SLP_OFF);
  endfunction
endpackage

// File: rtl/pwrbtn_hold_timer.sv
module pwrbtn_hold_timer #(
  parameter int unsigned HOLD_TICKS = 4,
  localparam int unsigned CNT_W = (HOLD_TICKS < 1) ? 1 : $clog2(HOLD_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hard_rst_i,
  input  logic btn_ni,
  input  logic tick_i,
  output logic press_o,
  output logic fire_o
);
  logic             low_q;
  logic             fired_q;
  logic [CNT_W-1:0] cnt_q;
  logic             held;
  logic             at_limit;

  assign held     = ~btn_ni;
  assign press_o  = held & ~low_q;
  assign at_limit = (cnt_q == CNT_W'(HOLD_TICKS));
  assign fire_o   = held & tick_i & ~fired_q & at_limit & ~hard_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b0;
    end else begin
      low_q <= held;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (hard_rst_i || !held) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (tick_i && !fired_q) begin
      if (at_limit) begin
        fired_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrbtn_status_regs.sv
module pwrbtn_status_regs
  import pwrbtn_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hard_rst_i,
  input  logic             press_i,
  input  logic             fire_i,
  input  logic [SLP_W-1:0] slp_state_i,
  input  logic             wr_i,
  input  logic             wr_sel_i,
  input  logic [WD_W-1:0]  wr_data_i,
  output logic             btn_sts_o,
  output logic             ovr_sts_o,
  output logic             btn_en_o,
  output logic             wake_lock_o,
  output logic             soft_off_o
);
  logic             clr_btn, clr_ovr, wr_en;
  logic             resume;
  logic [SLP_W-1:0] slp_q;

  assign clr_btn = wr_i && (wr_sel_i == SEL_STATUS) && wr_data_i[BIT_BTN];
  assign clr_ovr = wr_i && (wr_sel_i == SEL_STATUS) && wr_data_i[BIT_OVR];
  assign wr_en   = wr_i && (wr_sel_i == SEL_ENABLE);
  assign resume  = (slp_q != SLP_AWAKE) && (slp_state_i == SLP_AWAKE);

  // Sticky flags survive hard_rst_i; priority: override > press > W1C
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_sts_o <= 1'b0;
      ovr_sts_o <= 1'b0;
    end else begin
      if (fire_i)       btn_sts_o <= 1'b0;
      else if (press_i) btn_sts_o <= 1'b1;
      else if (clr_btn) btn_sts_o <= 1'b0;

      if (fire_i)       ovr_sts_o <= 1'b1;
      else if (clr_ovr) ovr_sts_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_en_o    <= 1'b0;
      wake_lock_o <= 1'b0;
      soft_off_o  <= 1'b0;
      slp_q       <= SLP_AWAKE;
    end else if (hard_rst_i) begin
      btn_en_o    <= 1'b0;
      wake_lock_o <= 1'b0;
      soft_off_o  <= 1'b0;
      slp_q       <= slp_state_i;
    end else begin
      slp_q      <= slp_state_i;
      soft_off_o <= fire_i;
      if (fire_i) begin
        btn_en_o    <= 1'b1;
        wake_lock_o <= 1'b1;
      end else begin
        if (resume) wake_lock_o <= 1'b0;
        if (wr_en && !wake_lock_o) btn_en_o <= wr_data_i[BIT_BTN];
      end
    end
  end
endmodule

// File: rtl/pwrbtn_event_route.sv
module pwrbtn_event_route
  import pwrbtn_pkg::*;
(
  input  logic             btn_sts_i,
  input  logic             btn_en_i,
  input  logic             sci_en_i,
  input  logic [SLP_W-1:0] slp_state_i,
  output logic             sci_o,
  output logic             smi_o,
  output logic             wake_o
);
  logic armed, awake;

  assign armed  = btn_sts_i & btn_en_i;
  assign awake  = (slp_state_i == SLP_AWAKE);
  assign sci_o  = armed & awake & sci_en_i;
  assign smi_o  = armed & awake & ~sci_en_i;
  assign wake_o = armed & is_sleeping(slp_state_i);
endmodule

// File: rtl/pwrbtn_ctl.sv
module pwrbtn_ctl
  import pwrbtn_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hard_rst_i,
  input  logic             btn_ni,
  input  logic [SLP_W-1:0] slp_state_i,
  input  logic             sci_en_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             wr_sel_i,
  input  logic [WD_W-1:0]  wr_data_i,
  output logic             btn_sts_o,
  output logic             ovr_sts_o,
  output logic             btn_en_o,
  output logic             wake_lock_o,
  output logic             sci_o,
  output logic             smi_o,
  output logic             wake_o,
  output logic             soft_off_o
);
  logic press, fire;

  pwrbtn_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hard_rst_i(hard_rst_i),
    .btn_ni    (btn_ni),
    .tick_i    (tick_i),
    .press_o   (press),
    .fire_o    (fire)
  );

  pwrbtn_status_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hard_rst_i (hard_rst_i),
    .press_i    (press),
    .fire_i     (fire),
    .slp_state_i(slp_state_i),
    .wr_i       (wr_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .btn_sts_o  (btn_sts_o),
    .ovr_sts_o  (ovr_sts_o),
    .btn_en_o   (btn_en_o),
    .wake_lock_o(wake_lock_o),
    .soft_off_o (soft_off_o)
  );

  pwrbtn_event_route u_route (
    .btn_sts_i  (btn_sts_o),
    .btn_en_i   (btn_en_o),
    .sci_en_i   (sci_en_i),
    .slp_state_i(slp_state_i),
    .sci_o      (sci_o),
    .smi_o      (smi_o),
    .wake_o     (wake_o)
  );
endmodule

// File: rtl/pwrbtn_ctl_chk.sv
module pwrbtn_ctl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hard_rst_i,
  input logic       btn_ni,
  input logic       wr_i,
  input logic       wr_sel_i,
  input logic [1:0] wr_data_i,
  input logic       btn_sts_o,
  input logic       ovr_sts_o,
  input logic       btn_en_o,
  input logic       wake_lock_o,
  input logic       sci_o,
  input logic       smi_o,
  input logic       wake_o,
  input logic       soft_off_o
);
  assert_req_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sci_o, smi_o, wake_o}) <= 1);

  assert_no_req_when_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !sci_o && !smi_o);

  assert_set_needs_press_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(btn_sts_o) |-> $past(!btn_ni));

  assert_clear_has_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(btn_sts_o) |-> ($past(wr_i && !wr_sel_i && wr_data_i[0]) || soft_off_o));

  assert_override_effects_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_off_o |-> ovr_sts_o && !btn_sts_o && btn_en_o && wake_lock_o);

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_off_o |=> !soft_off_o);

  assert_lock_keeps_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_lock_o |-> btn_en_o);

  assert_hard_rst_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> !btn_en_o && !wake_lock_o && !soft_off_o);
endmodule

bind pwrbtn_ctl pwrbtn_ctl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hard_rst_i (hard_rst_i),
  .btn_ni     (btn_ni),
  .wr_i       (wr_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .btn_sts_o  (btn_sts_o),
  .ovr_sts_o  (ovr_sts_o),
  .btn_en_o   (btn_en_o),
  .wake_lock_o(wake_lock_o),
  .sci_o      (sci_o),
  .smi_o      (smi_o),
  .wake_o     (wake_o),
  .soft_off_o (soft_off_o)
);

// File: tb/tb_pwrbtn_ctl.sv
module tb_pwrbtn_ctl;
  localparam int unsigned HOLD = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hard_rst_i = 1'b0;
  logic       btn_ni = 1'b1;
  logic [2:0] slp_state_i = 3'd0;
  logic       sci_en_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       wr_sel_i = 1'b0;
  logic [1:0] wr_data_i = 2'b00;
  logic btn_sts_o, ovr_sts_o, btn_en_o, wake_lock_o;
  logic sci_o, smi_o, wake_o, soft_off_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pwrbtn_ctl #(.HOLD_TICKS(HOLD)) dut (.*);

  // vector: slp[7:5] sci_en[4] en[3] exp_sci[2] exp_smi[1] exp_wake[0]
  localparam logic [7:0] VEC [8] = '{
    {3'd0, 1'b1, 1'b1, 3'b100},
    {3'd0, 1'b0, 1'b1, 3'b010},
    {3'd0, 1'b1, 1'b0, 3'b000},
    {3'd3, 1'b1, 1'b1, 3'b001},
    {3'd5, 1'b0, 1'b1, 3'b001},
    {3'd1, 1'b0, 1'b0, 3'b000},
    {3'd4, 1'b1, 1'b1, 3'b001},
    {3'd2, 1'b0, 1'b1, 3'b001}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic sel, input logic [1:0] d);
    wr_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step();
    wr_i = 1'b0; wr_data_i = 2'b00;
  endtask

  task automatic tick();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(); step();
    rst_ni = 1'b1;
    step();
    // R11 reset state
    chk("R11 sts", btn_sts_o, 0);   chk("R11 ovr", ovr_sts_o, 0);
    chk("R11 en", btn_en_o, 0);     chk("R11 lock", wake_lock_o, 0);
    chk("R11 soft_off", soft_off_o, 0);
    chk("R11 sci", sci_o, 0);       chk("R11 wake", wake_o, 0);

    // R1 press sets status with enable low
    btn_ni = 1'b0; step();
    chk("R1 sts on press", btn_sts_o, 1);
    chk("R1 en still low", btn_en_o, 0);
    btn_ni = 1'b1; step();

    // R7/R8 routing table
    foreach (VEC[i]) begin
      wr(1'b1, {1'b0, VEC[i][3]});
      slp_state_i = VEC[i][7:5]; sci_en_i = VEC[i][4];
      step();
      chk("R7 sci", sci_o, VEC[i][2]);
      chk("R7 smi", smi_o, VEC[i][1]);
      chk("R8 wake", wake_o, VEC[i][0]);
    end
    slp_state_i = 3'd0; sci_en_i = 1'b1;
    wr(1'b1, 2'b00);
    step();

    // R2 write-zero no effect, write-one clears
    wr(1'b0, 2'b10); step();
    chk("R2 zero keeps sts", btn_sts_o, 1);
    wr(1'b0, 2'b01); step();
    chk("R2 one clears sts", btn_sts_o, 0);

    // R3 press beats same-cycle clear
    btn_ni = 1'b0;
    wr(1'b0, 2'b01);
    chk("R3 set wins", btn_sts_o, 1);

    // R4 hold: HOLD ticks no override, release restarts
    for (int k = 0; k < HOLD; k++) tick();
    chk("R4 no fire at limit", ovr_sts_o, 0);
    btn_ni = 1'b1; step();
    btn_ni = 1'b0; step();
    for (int k = 0; k < HOLD; k++) tick();
    chk("R4 restart no fire", ovr_sts_o, 0);
    chk("R4 restart no soft_off", soft_off_o, 0);
    tick();
    // R5 override effects
    chk("R5 soft_off pulse", soft_off_o, 1);
    chk("R5 ovr set", ovr_sts_o, 1);
    chk("R5 sts cleared", btn_sts_o, 0);
    chk("R5 en forced", btn_en_o, 1);
    chk("R5 lock", wake_lock_o, 1);
    step();
    chk("R5 pulse one cycle", soft_off_o, 0);

    // R6 once per press
    wr(1'b0, 2'b10);
    for (int k = 0; k < HOLD + 3; k++) tick();
    chk("R6 no refire ovr", ovr_sts_o, 0);
    chk("R6 no refire soft_off", soft_off_o, 0);
    btn_ni = 1'b1; step();

    // R9 lock blocks disable, resume drops lock
    wr(1'b1, 2'b00);
    chk("R9 en held", btn_en_o, 1);
    slp_state_i = 3'd5; step();
    chk("R9 lock stays asleep", wake_lock_o, 1);
    slp_state_i = 3'd0; step();
    chk("R9 lock drops on resume", wake_lock_o, 0);
    wr(1'b1, 2'b00);
    chk("R9 en writable", btn_en_o, 0);

    // R10 hard reset keeps flags
    wr(1'b0, 2'b11);
    btn_ni = 1'b0;
    for (int k = 0; k < HOLD + 1; k++) tick();
    chk("R10 pre ovr", ovr_sts_o, 1);
    btn_ni = 1'b1; step();
    btn_ni = 1'b0; step();
    chk("R10 pre sts", btn_sts_o, 1);
    for (int k = 0; k < HOLD; k++) tick();
    hard_rst_i = 1'b1; step(); hard_rst_i = 1'b0;
    chk("R10 en cleared", btn_en_o, 0);
    chk("R10 lock cleared", wake_lock_o, 0);
    chk("R10 sts kept", btn_sts_o, 1);
    chk("R10 ovr kept", ovr_sts_o, 1);
    wr(1'b0, 2'b10);
    tick();
    chk("R10 count cleared", soft_off_o, 0);
    chk("R10 count cleared ovr", ovr_sts_o, 0);
    btn_ni = 1'b1; step();

    finish_run();
  end
endmodule